// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary Read-Out

This block keeps the time of day and the calendar date. Once per second a tick moves the seconds forward, and any carry ripples on through minutes, hours, day of week, day of month, month and a two-digit year. The rollover uses the real month lengths. February has 29 days in leap years, and the leap test uses the full year, formed from a century parameter and the two-digit year.

Software sets the time by presenting seven field bytes together with a load strobe, and all fields are written at once. The time is held internally in binary. Each output byte is encoded from that binary state using two mode inputs: packed BCD or plain binary, and 12-hour or 24-hour. A load byte is decoded under the same modes that are active in its cycle. A load takes priority over a tick that arrives in the same cycle.

Top module: `cal_time_counter`

## Requirements
- R1: On a tick, seconds count up and go from 59 to 0, carrying into minutes. Minutes go from 59 to 0, carrying into hours. Hours go from 23 to 0, carrying into the day.
- R2: Day of week counts 1 to 7 and goes back to 1 on each day carry.
- R3: On a day carry, day of month goes back to 1 and the month advances once the day has reached the month length. Month lengths in months 1 to 12 are 31,28,31,30,31,30,31,31,30,31,30,31.
- R4: February has 29 days when the full year (CENTURY*100 + two-digit year, default century 20) is divisible by 4 and is either not divisible by 100 or divisible by 400. With the default, years 00 and 04 are leap years and 01 is not.
- R5: Passing day 31 of month 12 gives day 1, month 1, and the year counts up. The year goes from 99 to 00.
- R6: With bin_mode_i=0 each output byte is packed BCD: tens in bits 7:4 and units in bits 3:0. With bin_mode_i=1 each output byte is the plain binary value.
- R7: With h24_mode_i=1 the hour byte holds 0..23. With h24_mode_i=0, bits 6:0 hold the hour modulo 12 and bit 7 is set for hours 12..23. Hour 0 reads as 0 with bit 7 clear.
- R8: A load strobe writes all seven fields from the input bytes, decoded under the current modes. In 12-hour mode a set bit 7 in the hour byte adds 12 to the decoded hour. The new value appears at the outputs in the cycle after the strobe.
- R9: When load and tick occur in the same cycle, the loaded value is stored and the tick is discarded.
- R10: Reset gives 00:00:00, day of week 1, day 1, month 1, year 00. With neither tick nor load the state does not change.
- R11: The outputs are re-encoded in the same cycle in which a mode input changes, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance pulse |
| load_i | input | 1 | Load strobe for all seven fields |
| ld_sec_i | input | 8 | Seconds to load |
| ld_min_i | input | 8 | Minutes to load |
| ld_hour_i | input | 8 | Hour to load (bit 7 = PM in 12-hour mode) |
| ld_wday_i | input | 8 | Day of week to load (1..7) |
| ld_mday_i | input | 8 | Day of month to load |
| ld_mon_i | input | 8 | Month to load (1..12) |
| ld_year_i | input | 8 | Two-digit year to load |
| bin_mode_i | input | 1 | 1 = binary, 0 = packed BCD |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| sec_o | output | 8 | Encoded seconds |
| min_o | output | 8 | Encoded minutes |
| hour_o | output | 8 | Encoded hour |
| wday_o | output | 8 | Encoded day of week |
| mday_o | output | 8 | Encoded day of month |
| mon_o | output | 8 | Encoded month |
| year_o | output | 8 | Encoded year |

## Verification
Two functions can fall in the same cycle: a software load and the one-second tick. The bench provokes the collision directly, with a load of a time one second before midnight at year end, so that a wrongly accepted tick would produce a visibly different date. It also provokes it at random, with tick and load drawn independently each cycle. The result is judged against a model in which the load always wins. Mode changes are also made in the same cycle as a load, to confirm that decoding uses the modes of that cycle.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int SEC_W      = 6;
    localparam int MIN_W      = 6;
    localparam int HOUR_W     = 5;
    localparam int WDAY_W     = 3;
    localparam int MDAY_W     = 5;
    localparam int MON_W      = 4;
    localparam int YEAR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int VAL_W      = 7;
    localparam int NUM_FIELDS = 7;
    localparam int HOUR_IDX   = 2;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [MDAY_W-1:0] mday;
        logic [WDAY_W-1:0] wday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    // binary value (0..99) to packed decimal digits
    function automatic logic [BYTE_W-1:0] to_bcd(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] units;
        tens  = v / VAL_W'(10);
        units = v % VAL_W'(10);
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] from_bcd(input logic [BYTE_W-1:0] b);
        return ({4'b0, b[7:4]} * BYTE_W'(10)) + {4'b0, b[3:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] enc_field(input logic [VAL_W-1:0] v,
                                                    input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [BYTE_W-1:0] dec_field(input logic [BYTE_W-1:0] b,
                                                    input logic bin);
        return bin ? b : from_bcd(b);
    endfunction
endpackage

// File: rtl/cal_month_len.sv
`timescale 1ns/1ps
module cal_month_len
    import cal_pkg::*;
#(
    parameter int CENTURY = 20
) (
    input  logic [MON_W-1:0]  mon_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic [MDAY_W-1:0] days_o
);
    // 100*CENTURY is a multiple of 4, so only the two-digit year decides
    // divisibility by 4; the century year itself falls back to CENTURY%4.
    localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

    logic leap;

    always_comb begin
        leap = (year_i[1:0] == 2'b00) && ((year_i != '0) || CENT_LEAP);
        unique case (mon_i)
            MON_W'(2):                     days_o = leap ? MDAY_W'(29) : MDAY_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):         days_o = MDAY_W'(30);
            default:                       days_o = MDAY_W'(31);
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t         cur_i,
    input  logic [MDAY_W-1:0] days_i,
    output cal_time_t         nxt_o
);
    logic sec_end, min_end, hour_end, mday_end, mon_end;

    always_comb begin
        sec_end  = (cur_i.sec  >= SEC_W'(59));
        min_end  = (cur_i.min  >= MIN_W'(59));
        hour_end = (cur_i.hour >= HOUR_W'(23));
        mday_end = (cur_i.mday >= days_i);
        mon_end  = (cur_i.mon  >= MON_W'(12));

        nxt_o     = cur_i;
        nxt_o.sec = sec_end ? '0 : cur_i.sec + SEC_W'(1);
        if (sec_end) begin
            nxt_o.min = min_end ? '0 : cur_i.min + MIN_W'(1);
            if (min_end) begin
                nxt_o.hour = hour_end ? '0 : cur_i.hour + HOUR_W'(1);
                if (hour_end) begin
                    nxt_o.wday = (cur_i.wday >= WDAY_W'(7)) ? WDAY_W'(1)
                                                            : cur_i.wday + WDAY_W'(1);
                    nxt_o.mday = mday_end ? MDAY_W'(1) : cur_i.mday + MDAY_W'(1);
                    if (mday_end) begin
                        nxt_o.mon = mon_end ? MON_W'(1) : cur_i.mon + MON_W'(1);
                        if (mon_end) begin
                            nxt_o.year = (cur_i.year >= YEAR_W'(99)) ? '0
                                                                     : cur_i.year + YEAR_W'(1);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_load_dec.sv
`timescale 1ns/1ps
module cal_load_dec
    import cal_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] bytes_i,
    input  logic                              bin_i,
    input  logic                              h24_i,
    output cal_time_t                         val_o
);
    logic [BYTE_W-1:0] dec [NUM_FIELDS];
    logic [BYTE_W-1:0] hour_raw;
    logic [BYTE_W-1:0] hour_val;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
        if (i == HOUR_IDX) begin : g_hour
            // 12-hour bytes carry the PM flag in bit 7; strip it before decoding
            assign dec[i] = dec_field(h24_i ? bytes_i[i] : {1'b0, bytes_i[i][6:0]}, bin_i);
        end else begin : g_plain
            assign dec[i] = dec_field(bytes_i[i], bin_i);
        end
    end

    always_comb begin
        hour_raw = dec[HOUR_IDX];
        hour_val = (!h24_i && bytes_i[HOUR_IDX][7]) ? hour_raw + BYTE_W'(12) : hour_raw;
        val_o.sec  = dec[0][SEC_W-1:0];
        val_o.min  = dec[1][MIN_W-1:0];
        val_o.hour = hour_val[HOUR_W-1:0];
        val_o.wday = dec[3][WDAY_W-1:0];
        val_o.mday = dec[4][MDAY_W-1:0];
        val_o.mon  = dec[5][MON_W-1:0];
        val_o.year = dec[6][YEAR_W-1:0];
    end
endmodule

// File: rtl/cal_out_enc.sv
`timescale 1ns/1ps
module cal_out_enc
    import cal_pkg::*;
(
    input  cal_time_t                         cur_i,
    input  logic                              bin_i,
    input  logic                              h24_i,
    output logic [NUM_FIELDS-1:0][BYTE_W-1:0] bytes_o
);
    logic [VAL_W-1:0] vals [NUM_FIELDS];
    logic             pm;
    logic [VAL_W-1:0] hour_full;

    always_comb begin
        hour_full = VAL_W'(cur_i.hour);
        pm        = (cur_i.hour >= HOUR_W'(12));
        vals[0]   = VAL_W'(cur_i.sec);
        vals[1]   = VAL_W'(cur_i.min);
        vals[2]   = (!h24_i && pm) ? hour_full - VAL_W'(12) : hour_full;
        vals[3]   = VAL_W'(cur_i.wday);
        vals[4]   = VAL_W'(cur_i.mday);
        vals[5]   = VAL_W'(cur_i.mon);
        vals[6]   = cur_i.year;
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_enc
        if (i == HOUR_IDX) begin : g_hour
            assign bytes_o[i] = enc_field(vals[i], bin_i) | {(!h24_i && pm), 7'b0};
        end else begin : g_plain
            assign bytes_o[i] = enc_field(vals[i], bin_i);
        end
    end
endmodule

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int CENTURY = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_mday_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_year_i,
    input  logic       bin_mode_i,
    input  logic       h24_mode_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    localparam cal_time_t RESET_TIME = '{year: '0, mon: MON_W'(1), mday: MDAY_W'(1),
                                         wday: WDAY_W'(1), hour: '0, min: '0, sec: '0};

    cal_time_t                         state_d, state_q;
    cal_time_t                         loaded, advanced;
    logic [MDAY_W-1:0]                 month_days;
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] ld_bytes, out_bytes;

    assign ld_bytes = {ld_year_i, ld_mon_i, ld_mday_i, ld_wday_i,
                       ld_hour_i, ld_min_i, ld_sec_i};

    cal_month_len #(.CENTURY(CENTURY)) u_len (
        .mon_i  (state_q.mon),
        .year_i (state_q.year),
        .days_o (month_days)
    );

    cal_advance u_adv (
        .cur_i  (state_q),
        .days_i (month_days),
        .nxt_o  (advanced)
    );

    cal_load_dec u_dec (
        .bytes_i (ld_bytes),
        .bin_i   (bin_mode_i),
        .h24_i   (h24_mode_i),
        .val_o   (loaded)
    );

    cal_out_enc u_enc (
        .cur_i   (state_q),
        .bin_i   (bin_mode_i),
        .h24_i   (h24_mode_i),
        .bytes_o (out_bytes)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = loaded;          // software write beats the tick
        end else if (tick_i) begin
            state_d = advanced;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_TIME;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o  = out_bytes[0];
    assign min_o  = out_bytes[1];
    assign hour_o = out_bytes[2];
    assign wday_o = out_bytes[3];
    assign mday_o = out_bytes[4];
    assign mon_o  = out_bytes[5];
    assign year_o = out_bytes[6];
endmodule

// File: rtl/cal_time_checker.sv
`timescale 1ns/1ps
module cal_time_checker
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       load_i,
    input logic [7:0] ld_sec_i,
    input logic       bin_mode_i,
    input logic       h24_mode_i,
    input cal_time_t  state_q,
    input logic [7:0] hour_o
);
    logic step;
    logic day_end;
    assign step    = tick_i && !load_i;
    assign day_end = step && state_q.sec == SEC_W'(59) && state_q.min == MIN_W'(59)
                     && state_q.hour == HOUR_W'(23);

    assert_sec_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step && state_q.sec < SEC_W'(59) |=> state_q.sec == $past(state_q.sec) + SEC_W'(1));

    assert_min_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step && state_q.sec == SEC_W'(59) && state_q.min == MIN_W'(59) |=> state_q.min == '0);

    assert_wday_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        day_end && state_q.wday == WDAY_W'(7) |=> state_q.wday == WDAY_W'(1));

    assert_year_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        day_end && state_q.mday == MDAY_W'(31) && state_q.mon == MON_W'(12)
        && state_q.year == YEAR_W'(99) |=> state_q.year == '0 && state_q.mon == MON_W'(1));

    assert_pm_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !h24_mode_i |-> hour_o[7] == (state_q.hour >= HOUR_W'(12)));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && tick_i && bin_mode_i && ld_sec_i < 8'd60
        |=> state_q.sec == $past(ld_sec_i[5:0]));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !load_i |=> $stable(state_q));
endmodule

bind cal_time_counter cal_time_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (load_i),
    .ld_sec_i   (ld_sec_i),
    .bin_mode_i (bin_mode_i),
    .h24_mode_i (h24_mode_i),
    .state_q    (state_q),
    .hour_o     (hour_o)
);

// File: tb/sim_cal_time_counter.sv
`timescale 1ns/1ps
module sim_cal_time_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, load = 1'b0;
    logic [7:0] l_sec = '0, l_min = '0, l_hour = '0, l_wday = '0;
    logic [7:0] l_mday = '0, l_mon = '0, l_year = '0;
    logic       bin = 1'b0, h24 = 1'b1;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int errs = 0, checks = 0;
    bit done = 0;
    int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;

    always #10 clk = ~clk;

    cal_time_counter u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
        .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_wday_i(l_wday),
        .ld_mday_i(l_mday), .ld_mon_i(l_mon), .ld_year_i(l_year),
        .bin_mode_i(bin), .h24_mode_i(h24),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
    );

    function automatic int dim(int mo, int y);
        int full = 2000 + y;
        bit leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        case (mo)
            2: return leap ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction

    function automatic logic [7:0] enc(int v, bit b);
        if (b) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(int h, bit b, bit t24);
        if (t24) return enc(h, b);
        return enc(h % 12, b) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    task automatic model_tick();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_mi++;
        if (m_mi < 60) return;
        m_mi = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0;
        m_w = (m_w == 7) ? 1 : m_w + 1;
        m_d++;
        if (m_d <= dim(m_mo, m_y)) return;
        m_d = 1; m_mo++;
        if (m_mo <= 12) return;
        m_mo = 1; m_y = (m_y + 1) % 100;
    endtask

    task automatic check(string req);
        logic [55:0] act, exp;
        act = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
        exp = {enc(m_s, bin), enc(m_mi, bin), enc_hr(m_h, bin, h24), enc(m_w, bin),
               enc(m_d, bin), enc(m_mo, bin), enc(m_y, bin)};
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; applies one cycle of stimulus
    task automatic step(bit tk, bit ld, int s, int mi, int h, int w, int d, int mo, int y);
        tick = tk; load = ld;
        l_sec = enc(s, bin); l_min = enc(mi, bin); l_hour = enc_hr(h, bin, h24);
        l_wday = enc(w, bin); l_mday = enc(d, bin); l_mon = enc(mo, bin); l_year = enc(y, bin);
        @(posedge clk);
        if (ld) begin
            m_s = s; m_mi = mi; m_h = h; m_w = w; m_d = d; m_mo = mo; m_y = y;
        end else if (tk) begin
            model_tick();
        end
        @(negedge clk);
        tick = 0; load = 0;
    endtask

    task automatic set_and_tick(int h, int d, int mo, int y, string req);
        step(0, 1, 59, 59, h, 3, d, mo, y);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check(req);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R10 reset state");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R10 idle hold");

        // year-end rollover, every field carries
        step(0, 1, 59, 59, 23, 7, 31, 12, 99);
        check("R8 load");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R1 R2 R5 year end");
        if ({wday_o, mday_o, mon_o, year_o} !== 32'h01010100) begin
            errs++; $display("FAIL R5: actual=%h expected=01010100",
                             {wday_o, mday_o, mon_o, year_o});
        end
        checks++;

        set_and_tick(23, 28, 2, 0, "R4 Feb 28 of leap year 00");
        set_and_tick(23, 29, 2, 0, "R3 Feb 29 to Mar 1");
        set_and_tick(23, 28, 2, 1, "R4 Feb 28 of non-leap year 01");
        set_and_tick(23, 28, 2, 4, "R4 Feb 28 of leap year 04");
        set_and_tick(23, 30, 4, 7, "R3 Apr 30");
        set_and_tick(23, 31, 1, 7, "R3 Jan 31");

        // same-cycle load and tick
        step(1, 1, 59, 59, 23, 7, 31, 12, 99);
        check("R9 load beats tick");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R10 hold after load");

        // 12-hour mode and PM flag
        h24 = 0;
        step(0, 1, 59, 59, 11, 2, 10, 6, 20);
        check("R7 R8 12h load 11 AM");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 noon reads 12 PM as 0 with flag");
        if (hour_o !== 8'h80) begin
            errs++; $display("FAIL R7: actual=%h expected=80", hour_o);
        end
        checks++;
        step(0, 1, 30, 15, 23, 2, 10, 6, 20);
        check("R8 PM hour byte adds 12");
        set_and_tick(23, 10, 6, 20, "R7 midnight in 12h mode");

        // mode changes re-encode without a clock edge
        step(0, 1, 47, 38, 19, 5, 25, 11, 63);
        bin = 1; #1;
        check("R6 R11 switch to binary");
        h24 = 1; #1;
        check("R11 switch to 24h");
        bin = 0; #1;
        check("R6 back to BCD");
        @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit tk = ($urandom % 4) != 0;
            bit ld = ($urandom % 16) == 0;
            int mo = 1 + $urandom % 12;
            int y = $urandom % 100;
            int d = 1 + $urandom % dim(mo, y);
            if ($urandom % 32 == 0) bin = ~bin;
            if ($urandom % 32 == 0) h24 = ~h24;
            step(tk, ld, ($urandom % 3 == 0) ? 59 : $urandom % 60,
                 ($urandom % 2 == 0) ? 59 : $urandom % 60,
                 ($urandom % 2 == 0) ? 23 : $urandom % 24,
                 1 + $urandom % 7, ($urandom % 2 == 0) ? dim(mo, y) : d, mo, y);
            check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule